// File: doc/BRIEF.md
# Planar Display Memory Read Latch

This block serves host reads from display memory laid out as four parallel byte planes. Every read strobe captures the full memory word, with one byte per plane, into a latch register. The same edge registers one result byte for the host. In plane mode the result is the byte of the selected plane. In compare mode the result is a per-pixel match mask: bit i is 1 when the colour formed by bit i of each plane agrees with a reference colour on every plane that takes part in the comparison.

The latch keeps its value until the next read strobe. A write path outside this block can therefore use it as its source of latched plane data. Address decoding and the write datapath are outside this block. The memory word presented at the strobe is assumed to already belong to the decoded address.

Top module: `vga_read_latch`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has latch equal to zero and rd_data equal to zero.
- R2: A clock edge with rd_stb high loads latch with mem_word, visible after that edge.
- R3: A clock edge with rd_stb low leaves latch unchanged, whatever mem_word holds.
- R4: With rd_stb high and rd_mode 0, rd_data after the edge equals bits [8*rd_plane+7 : 8*rd_plane] of the mem_word being latched. Plane p occupies byte lane p, and lane 0 is bits [7:0].
- R5: With rd_stb high and rd_mode 1, bit i of rd_data after the edge is 1 exactly when, for every plane p with dc_mask[p] = 1, bit 8*p+i of mem_word equals cmp_color[p].
- R6: In compare mode with dc_mask equal to 0, rd_data becomes 8'hFF regardless of mem_word and cmp_color.
- R7: rd_data is registered. It changes only on an edge with rd_stb high and holds its value between reads.
- R8: Changes on rd_mode, rd_plane, cmp_color, dc_mask or mem_word while rd_stb is low affect neither rd_data nor latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| mem_word | input | 32 | Four plane bytes at the decoded address, plane p in byte lane p |
| rd_mode | input | 1 | 0 selects plane byte, 1 selects colour compare |
| rd_plane | input | 2 | Plane returned in plane mode |
| cmp_color | input | 4 | Reference colour, one bit per plane |
| dc_mask | input | 4 | Per-plane compare enable; 0 drops that plane from the compare |
| rd_data | output | 8 | Registered read result |
| latch | output | 32 | Plane latch shared with the write path |

## Verification
The assertions assume that the memory word, mode, plane select and compare inputs are stable and meaningful at any edge where rd_stb is high. They also assume that rst_n is a clean synchronous level. The bench changes every input only on the falling edge, so each strobed edge sees settled values. It scrambles all inputs during idle cycles to show that nothing but a strobe moves the latch or the result. Random reads cover every plane select and every compare and don't-care pattern. Directed reads pin down the all-excluded compare and exact per-plane matches.

// File: rtl/vga_rdl_pkg.sv
// Shared definitions for the planar read latch unit.
// Assumes four byte-wide planes by default; the geometry is parameterised at each module.
package vga_rdl_pkg;
    typedef enum logic {
        RDM_PLANE   = 1'b0,
        RDM_COMPARE = 1'b1
    } rd_mode_e;

    localparam int unsigned DEF_PLANES = 4;
    localparam int unsigned DEF_LANE_W = 8;
endpackage

// File: rtl/vga_lane_expand.sv
// Widens a one-bit-per-plane vector so that bit n fills byte lane n with ones.
// Purely combinational; assumes lanes are packed low plane first.
module vga_lane_expand #(
    parameter int unsigned PLANES = vga_rdl_pkg::DEF_PLANES,
    parameter int unsigned LANE_W = vga_rdl_pkg::DEF_LANE_W,
    localparam int unsigned WORD_W = PLANES * LANE_W
) (
    input  logic [PLANES-1:0] bits_in,
    output logic [WORD_W-1:0] word_out
);
    // one replicated lane per plane bit
    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        assign word_out[p*LANE_W +: LANE_W] = {LANE_W{bits_in[p]}};
    end
endmodule

// File: rtl/vga_colour_match.sv
// Computes the per-pixel colour match byte of compare mode.
// A pixel matches when every enabled plane bit equals its reference bit.
// Combinational; assumes the caller registers the result.
module vga_colour_match #(
    parameter int unsigned PLANES = vga_rdl_pkg::DEF_PLANES,
    parameter int unsigned LANE_W = vga_rdl_pkg::DEF_LANE_W,
    localparam int unsigned WORD_W = PLANES * LANE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [PLANES-1:0] cmp_color,
    input  logic [PLANES-1:0] dc_mask,
    output logic [LANE_W-1:0] match
);
    logic [WORD_W-1:0] cmp_wide;
    logic [WORD_W-1:0] dc_wide;
    logic [WORD_W-1:0] mismatch;
    logic [LANE_W-1:0] acc [PLANES];

    vga_lane_expand #(.PLANES(PLANES), .LANE_W(LANE_W)) u_cmp_exp (
        .bits_in  (cmp_color),
        .word_out (cmp_wide)
    );

    vga_lane_expand #(.PLANES(PLANES), .LANE_W(LANE_W)) u_dc_exp (
        .bits_in  (dc_mask),
        .word_out (dc_wide)
    );

    // differing bits, restricted to the planes taking part
    assign mismatch = (word ^ cmp_wide) & dc_wide;

    // fold the planes' mismatch lanes into one lane
    for (genvar p = 0; p < PLANES; p++) begin : g_fold
        if (p == 0) begin : g_first
            assign acc[p] = mismatch[LANE_W-1:0];
        end else begin : g_next
            assign acc[p] = acc[p-1] | mismatch[p*LANE_W +: LANE_W];
        end
    end

    // a pixel with no mismatching plane is a match
    assign match = ~acc[PLANES-1];
endmodule

// File: rtl/vga_plane_pick.sv
// Selects one plane's byte lane out of the full plane word.
// Combinational; assumes sel is below PLANES.
module vga_plane_pick #(
    parameter int unsigned PLANES = vga_rdl_pkg::DEF_PLANES,
    parameter int unsigned LANE_W = vga_rdl_pkg::DEF_LANE_W,
    localparam int unsigned WORD_W = PLANES * LANE_W,
    localparam int unsigned SEL_W  = (PLANES > 1) ? $clog2(PLANES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);
    logic [LANE_W-1:0] lanes [PLANES];

    // split the word into addressable lanes
    for (genvar p = 0; p < PLANES; p++) begin : g_split
        assign lanes[p] = word[p*LANE_W +: LANE_W];
    end

    // pick the requested lane
    assign lane = lanes[sel];
endmodule

// File: rtl/vga_read_latch.sv
// Host read path of four-plane display memory.
// On each read strobe the plane latch captures mem_word, and rd_data registers
// either the selected plane byte or the colour-compare mask, both formed from
// the word being latched. Assumes mem_word is already at the decoded address.
// Synchronous active-low reset.
module vga_read_latch #(
    parameter int unsigned PLANES = vga_rdl_pkg::DEF_PLANES,
    parameter int unsigned LANE_W = vga_rdl_pkg::DEF_LANE_W,
    localparam int unsigned WORD_W = PLANES * LANE_W,
    localparam int unsigned SEL_W  = (PLANES > 1) ? $clog2(PLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [WORD_W-1:0] mem_word,
    input  logic              rd_mode,
    input  logic [SEL_W-1:0]  rd_plane,
    input  logic [PLANES-1:0] cmp_color,
    input  logic [PLANES-1:0] dc_mask,
    output logic [LANE_W-1:0] rd_data,
    output logic [WORD_W-1:0] latch
);
    import vga_rdl_pkg::*;

    logic [LANE_W-1:0] plane_byte;
    logic [LANE_W-1:0] match_byte;
    logic [LANE_W-1:0] result;
    rd_mode_e          mode;

    assign mode = rd_mode_e'(rd_mode);

    vga_plane_pick #(.PLANES(PLANES), .LANE_W(LANE_W)) u_pick (
        .word (mem_word),
        .sel  (rd_plane),
        .lane (plane_byte)
    );

    vga_colour_match #(.PLANES(PLANES), .LANE_W(LANE_W)) u_match (
        .word      (mem_word),
        .cmp_color (cmp_color),
        .dc_mask   (dc_mask),
        .match     (match_byte)
    );

    // choose the result byte by read mode
    always_comb begin
        unique case (mode)
            RDM_COMPARE: result = match_byte;
            default:     result = plane_byte;
        endcase
    end

    // capture the plane word on each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
        end else if (rd_stb) begin
            latch <= mem_word;
        end
    end

    // register the host result byte on each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= result;
        end
    end

    // R1: reset clears both registers
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (latch == '0 && rd_data == '0));

    // R2: latch follows the word seen at the strobe
    p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> latch == $past(mem_word));

    // R3 / R8: latch is still without a strobe
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd_stb) |=> $stable(latch));

    // R7 / R8: result is still without a strobe
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd_stb) |=> $stable(rd_data));

    // R4: plane mode returns the selected lane of the latched word
    p_plane_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_mode == 1'b0) |=>
            rd_data == LANE_W'(latch >> (32'($past(rd_plane)) * LANE_W)));

    // R6: compare with every plane excluded matches all pixels
    p_all_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_mode == 1'b1 && dc_mask == '0) |=> rd_data == '1);
endmodule

// File: tb/vga_read_latch_tb.sv
module vga_read_latch_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [31:0] mem_word = '0;
    logic        rd_mode = 1'b0;
    logic [1:0]  rd_plane = '0;
    logic [3:0]  cmp_color = '0;
    logic [3:0]  dc_mask = '0;
    logic [7:0]  rd_data;
    logic [31:0] latch;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    vga_read_latch u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mem_word(mem_word),
        .rd_mode(rd_mode), .rd_plane(rd_plane), .cmp_color(cmp_color),
        .dc_mask(dc_mask), .rd_data(rd_data), .latch(latch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_byte(input logic [31:0] w, input logic m,
                                            input logic [1:0] pl, input logic [3:0] c,
                                            input logic [3:0] d);
        logic [7:0] r;
        if (!m) return w[pl*8 +: 8];
        for (int i = 0; i < 8; i++) begin
            r[i] = 1'b1;
            for (int p = 0; p < 4; p++)
                if (d[p] && (w[p*8+i] != c[p])) r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one strobed read, then check both outputs after the edge
    task automatic do_read(input string req, input logic [31:0] w, input logic m,
                           input logic [1:0] pl, input logic [3:0] c, input logic [3:0] d);
        logic [7:0] e;
        e = ref_byte(w, m, pl, c, d);
        mem_word = w; rd_mode = m; rd_plane = pl; cmp_color = c; dc_mask = d;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, {24'h0, rd_data}, {24'h0, e});
        check("R2", latch, w);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 data", {24'h0, rd_data}, 32'h0);
        check("R1 latch", latch, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: every plane lane
        for (int p = 0; p < 4; p++)
            do_read("R4", 32'h44_33_22_11, 1'b0, 2'(p), 4'h0, 4'h0);
        // R6: no plane compared
        do_read("R6", 32'h5A_A5_3C_C3, 1'b1, 2'd0, 4'h9, 4'h0);
        // R5: exact match pattern, cmp=0101 with all planes enabled
        do_read("R5", 32'h0F_F0_0F_F0, 1'b1, 2'd0, 4'b1010, 4'hF);
        do_read("R5", 32'h0F_F0_0F_F0, 1'b1, 2'd0, 4'b0101, 4'hF);
        do_read("R5", 32'hFF_00_AA_55, 1'b1, 2'd0, 4'b1000, 4'b1001);

        // R3 / R7 / R8: scramble inputs without strobe
        for (int k = 0; k < 6; k++) begin
            mem_word = $urandom; rd_mode = 1'($urandom); rd_plane = 2'($urandom);
            cmp_color = 4'($urandom); dc_mask = 4'($urandom);
            @(negedge clk);
        end
        check("R3", latch, 32'hFF_00_AA_55);
        check("R7 R8", {24'h0, rd_data}, {24'h0, ref_byte(32'hFF_00_AA_55, 1'b1, 2'd0, 4'b1000, 4'b1001)});

        // random reads with random idle gaps
        for (int k = 0; k < 300; k++) begin
            logic [31:0] w;
            logic [7:0] keep;
            w = $urandom;
            do_read("R4 R5", w, 1'($urandom), 2'($urandom), 4'($urandom), 4'($urandom));
            keep = rd_data;
            repeat ($urandom_range(0, 2)) begin
                mem_word = $urandom; cmp_color = 4'($urandom); rd_mode = 1'($urandom);
                @(negedge clk);
            end
            check("R8 latch", latch, w);
            check("R7", {24'h0, rd_data}, {24'h0, keep});
        end

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 data", {24'h0, rd_data}, 32'h0);
        check("R1 latch", latch, 32'h0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule